// File: doc/BRIEF.md
# Flag-Setting Logical Test Unit

This block is an execution slice that runs a bitwise test between a register operand and a second operand that an upstream shifter may already have shifted. Two tests are offered: an AND-test, which checks chosen bits of the first operand against a mask, and an XOR-test, which checks two values for equality or for a difference in sign. The computed word is discarded. Only the condition flags (negative, zero, carry, overflow) are kept, in a register inside the block.

The carry flag never comes from the logic operation. It takes the shifter's carry-out when the shifter reports one, and otherwise keeps its previous value. The overflow flag is left untouched by both tests. A new flag value is written only when an issue strobe and a condition-pass input are both high. The unit also drives a register-file write enable that is always low, so a shared datapath can merge it without decoding the operation.

Top module: `flagtest_unit`

## Requirements
- R1: A synchronous active-high reset sets all four flags (N, Z, C, V) to 0 at the next rising edge.
- R2: With op_sel_i = 0 (AND-test), an update sets N to bit 31 of opa_i & opb_i and sets Z when opa_i & opb_i is all zeros.
- R3: With op_sel_i = 1 (XOR-test), an update sets N to opa_i[31] ^ opb_i[31] and sets Z when opa_i ^ opb_i is all zeros, so two equal operands always set Z.
- R4: On an update, C takes shc_i when shc_valid_i is 1 and keeps its old value when shc_valid_i is 0, for either operation.
- R5: V is never changed by either operation. After reset it reads 0 until the next reset.
- R6: The flags update only at a rising edge where issue_i and cond_pass_i are both 1. In every other cycle all four flags hold, whatever the operands and shifter inputs are.
- R7: rf_we_o is 0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| issue_i | input | 1 | Operation issue strobe |
| cond_pass_i | input | 1 | Condition evaluated true for this operation |
| op_sel_i | input | 1 | 0 = AND-test, 1 = XOR-test |
| opa_i | input | 32 | First operand (register value) |
| opb_i | input | 32 | Second operand, possibly shifted |
| shc_i | input | 1 | Carry-out from the operand shifter |
| shc_valid_i | input | 1 | shc_i carries a real carry for this operation |
| flag_n_o | output | 1 | Registered negative flag |
| flag_z_o | output | 1 | Registered zero flag |
| flag_c_o | output | 1 | Registered carry flag |
| flag_v_o | output | 1 | Registered overflow flag |
| rf_we_o | output | 1 | Register-file write enable, always low |

## Verification
The hardest case to reach is a C flag that holds across an update that does change N and Z. It appears only when a firing operation arrives with shc_valid_i low, right after C was loaded with 1. Otherwise a stuck or wrongly cleared carry looks the same as a correct one. The stimulus first loads C with 1 through a valid shifter carry. It then issues AND-tests and XOR-tests with the carry invalid and shc_i driven to the opposite value. Gated cycles with live operands and a valid carry come next. A long stretch of mixed random issue, condition, operation and carry values then compares every flag against a behavioural model on every clock.

// File: rtl/flagtest_pkg.sv
package flagtest_pkg;
  typedef enum logic [0:0] {
    OP_AND_TEST = 1'b0,
    OP_XOR_TEST = 1'b1
  } test_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  localparam flags_t FLAGS_CLEAR = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0};
endpackage

// File: rtl/ftu_logic.sv
module ftu_logic
  import flagtest_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  test_op_e           op,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic               n_out,
  output logic               z_out
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] res;

  always_comb begin
    unique case (op)
      OP_AND_TEST: res = a & b;
      OP_XOR_TEST: res = a ^ b;
      default:     res = a & b;
    endcase
  end

  assign n_out = res[MSB];
  assign z_out = ~|res;

  // R3: equal operands under the XOR-test always give zero
  always_comb begin
    if (op == OP_XOR_TEST && a == b)
      a_r3_equal_sets_z: assert (z_out === 1'b1 || $isunknown(a));
  end
endmodule

// File: rtl/ftu_carry_sel.sv
module ftu_carry_sel (
  input  logic shc_valid,
  input  logic shc,
  input  logic c_old,
  output logic c_next
);
  always_comb begin
    if (shc_valid) c_next = shc;
    else           c_next = c_old;
  end
endmodule

// File: rtl/ftu_flagreg.sv
module ftu_flagreg
  import flagtest_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   upd_en,
  input  logic   n_next,
  input  logic   z_next,
  input  logic   c_next,
  output flags_t flags
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= FLAGS_CLEAR;
    end else if (upd_en) begin
      flags.n <= n_next;
      flags.z <= z_next;
      flags.c <= c_next;
    end
  end

  // R1: reset clears all flags
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (flags == FLAGS_CLEAR));

  // R6: no update strobe, all flags hold
  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(flags));

  // R5: overflow flag never moves outside reset
  a_r5_v_untouched: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(flags.v));
endmodule

// File: rtl/flagtest_unit.sv
module flagtest_unit
  import flagtest_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_i,
  input  logic             cond_pass_i,
  input  logic             op_sel_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             shc_i,
  input  logic             shc_valid_i,
  output logic             flag_n_o,
  output logic             flag_z_o,
  output logic             flag_c_o,
  output logic             flag_v_o,
  output logic             rf_we_o
);
  localparam int MSB = WIDTH - 1;

  test_op_e op;
  logic     n_calc;
  logic     z_calc;
  logic     c_calc;
  logic     fire;
  flags_t   flags_q;

  assign op   = test_op_e'(op_sel_i);
  assign fire = issue_i & cond_pass_i;

  ftu_logic #(.WIDTH(WIDTH)) u_logic (
    .op    (op),
    .a     (opa_i),
    .b     (opb_i),
    .n_out (n_calc),
    .z_out (z_calc)
  );

  ftu_carry_sel u_carry (
    .shc_valid (shc_valid_i),
    .shc       (shc_i),
    .c_old     (flags_q.c),
    .c_next    (c_calc)
  );

  ftu_flagreg u_flags (
    .clk    (clk),
    .rst    (rst),
    .upd_en (fire),
    .n_next (n_calc),
    .z_next (z_calc),
    .c_next (c_calc),
    .flags  (flags_q)
  );

  assign flag_n_o = flags_q.n;
  assign flag_z_o = flags_q.z;
  assign flag_c_o = flags_q.c;
  assign flag_v_o = flags_q.v;
  assign rf_we_o  = 1'b0;

  // R2: AND-test zero flag follows the masked operand
  a_r2_and_zero: assert property (@(posedge clk) disable iff (rst)
    (fire && !op_sel_i) |=> (flag_z_o == ($past(opa_i & opb_i) == '0)));

  // R3: XOR-test negative flag is the sign difference
  a_r3_xor_sign: assert property (@(posedge clk) disable iff (rst)
    (fire && op_sel_i) |=> (flag_n_o == ($past(opa_i[MSB]) ^ $past(opb_i[MSB]))));

  // R4: carry loads only from a valid shifter carry
  a_r4_carry_load: assert property (@(posedge clk) disable iff (rst)
    (fire && shc_valid_i) |=> (flag_c_o == $past(shc_i)));

  a_r4_carry_hold: assert property (@(posedge clk) disable iff (rst)
    (fire && !shc_valid_i) |=> $stable(flag_c_o));
endmodule

// File: tb/sim_flagtest_unit.sv
module sim_flagtest_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_i = 1'b0, cond_pass_i = 1'b0, op_sel_i = 1'b0;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic        shc_i = 1'b0, shc_valid_i = 1'b0;
  logic        flag_n_o, flag_z_o, flag_c_o, flag_v_o, rf_we_o;

  int errors = 0;
  int checks = 0;
  string tag = "R1";
  int m_n = 0, m_z = 0, m_c = 0, m_v = 0;

  always #2 clk = ~clk;

  flagtest_unit u0 (
    .clk(clk), .rst(rst), .issue_i(issue_i), .cond_pass_i(cond_pass_i),
    .op_sel_i(op_sel_i), .opa_i(opa_i), .opb_i(opb_i), .shc_i(shc_i),
    .shc_valid_i(shc_valid_i), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
    .flag_c_o(flag_c_o), .flag_v_o(flag_v_o), .rf_we_o(rf_we_o)
  );

  // Behavioural reference model, advanced at every rising edge
  always @(posedge clk) begin
    longint unsigned r;
    if (rst) begin
      m_n = 0; m_z = 0; m_c = 0; m_v = 0;
    end else if (issue_i && cond_pass_i) begin
      r = op_sel_i ? (longint'(opa_i) ^ longint'(opb_i)) : (longint'(opa_i) & longint'(opb_i));
      m_n = int'((r >> 31) & 1);
      m_z = (r == 0) ? 1 : 0;
      if (shc_valid_i) m_c = int'(shc_i);
    end
  end

  task automatic chk1(string name, logic act, int exp);
    checks++;
    if (act !== exp[0]) begin
      errors++;
      $display("FAIL %s flag %s: actual=%b expected=%0d", tag, name, act, exp);
    end
  endtask

  task automatic compare();
    chk1("N", flag_n_o, m_n);
    chk1("Z", flag_z_o, m_z);
    chk1("C", flag_c_o, m_c);
    chk1("V(R5)", flag_v_o, m_v);
    chk1("WE(R7)", rf_we_o, 0);
  endtask

  // One cycle: drive at the falling edge, compare at the next falling edge
  task automatic step(string t, logic is, logic cp, logic op,
                      logic [31:0] a, logic [31:0] b, logic sc, logic sv);
    issue_i = is; cond_pass_i = cp; op_sel_i = op;
    opa_i = a; opb_i = b; shc_i = sc; shc_valid_i = sv;
    @(negedge clk);
    tag = t;
    compare();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    @(negedge clk);
    // R1: reset with live inputs
    rst = 1'b1;
    step("R1", 1, 1, 1, 32'h8000_0000, 32'h0, 1, 1);
    step("R1", 1, 1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1);
    rst = 1'b0;
    // R2: AND-test patterns
    step("R2", 1, 1, 0, 32'hFFFF_0000, 32'h0000_FFFF, 0, 0);
    step("R2", 1, 1, 0, 32'h8000_0001, 32'h8000_0000, 0, 0);
    step("R2", 1, 1, 0, 32'h0000_03F8, 32'h0000_0100, 0, 0);
    // R3: XOR-test, equality and sign
    step("R3", 1, 1, 1, 32'h1234_5678, 32'h1234_5678, 0, 0);
    step("R3", 1, 1, 1, 32'h8000_0000, 32'h0000_0001, 0, 0);
    step("R3", 1, 1, 1, 32'hF000_0000, 32'h8000_0000, 0, 0);
    // R4: load carry 1, then hold it with shc_i driven opposite
    step("R4", 1, 1, 0, 32'h1, 32'h1, 1, 1);
    step("R4", 1, 1, 0, 32'h8000_0000, 32'hC000_0000, 0, 0);
    step("R4", 1, 1, 1, 32'h5, 32'h5, 0, 0);
    step("R4", 1, 1, 1, 32'h5, 32'h4, 0, 1);
    step("R4", 1, 1, 0, 32'h5, 32'h4, 1, 0);
    // R6: gated cycles with live operands and a valid carry
    step("R6", 0, 1, 1, 32'h8000_0000, 32'h0, 1, 1);
    step("R6", 1, 0, 0, 32'h0, 32'h0, 1, 1);
    step("R6", 0, 0, 1, 32'h7, 32'h7, 1, 1);
    // Mixed random traffic against the model
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = (i % 5 == 0) ? a : $urandom;
      step("R6", 1'($urandom), 1'($urandom), 1'($urandom), a, b,
           1'($urandom), 1'($urandom));
    end
    // R1: reset again after traffic
    step("R4", 1, 1, 0, 32'h8000_0000, 32'h8000_0000, 1, 1);
    rst = 1'b1;
    step("R1", 1, 1, 0, 32'h8000_0000, 32'h8000_0000, 1, 1);
    rst = 1'b0;
    step("R5", 1, 1, 1, 32'hFFFF_FFFF, 32'h0, 1, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule